// File: doc/BRIEF.md
# Wide-Write Narrow-Read Dual-Port RAM

This block is a single-clock simple dual-port on-chip memory. The write port stores a full 32-bit word at a word address on each enabled clock edge. The read port returns one 8-bit byte per cycle at a byte address. The upper bits of the read address choose the word. Its two lowest bits choose the byte lane inside that word.

The storage is kept as one byte-wide array with four times as many entries as there are words. A write fills the four byte locations of a word on the same edge. The read is a single narrow lookup into that array, so the design has no 32-bit read followed by a separate lane multiplexer. The read address is captured on the clock edge. Read data is not registered: it follows the captured address combinationally in the cycle after the edge. The number of words is set by the parameter `AW` and equals 2^AW.

Top module: `asym_ram`

## Requirements
- R1: When `wr_en` is high at a rising edge outside reset, all four bytes of word `wr_addr` are replaced by `wr_data`.
- R2: When `wr_en` is low at a rising edge, no stored byte changes, whatever values `wr_addr` and `wr_data` carry.
- R3: The read address `rd_addr` is AW+2 bits wide. Bits [AW+1:2] select the word and bits [1:0] select the lane. Lane 0 is word bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24.
- R4: `rd_addr` is captured at each rising edge. `rd_data` shows the byte at the captured address from just after that edge. It does not react to changes of `rd_addr` between edges.
- R5: When a write and a read target the same word at the same edge, `rd_data` shows the selected byte of the newly written word right after that edge (write-first).
- R6: While `rst_n` is low at a rising edge, the captured read address becomes 0 and writes are blocked. `rd_data` then shows lane 0 of word 0.
- R7: The memory holds 2^AW independent words. Every byte lane of every word can be written and read back without disturbing any other word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable, sampled at the rising edge |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 32 | Word to store |
| rd_addr | input | AW+2 | Byte address of the read |
| rd_data | output | 8 | Byte at the captured read address (combinational) |

## Verification
The assertions run on every cycle and check four things. The read address is captured each edge. It is cleared during reset. The output holds steady when no write occurs and the address does not move. A same-word collision returns the selected byte of the new word. Only the bench's scenarios can show that the whole array keeps independent words and puts each lane at the right bit position. They also show that a disabled write leaves the old contents in place, and that a write attempted during reset is dropped. The bench does this with sweeps and random traffic against its own byte model.

// File: rtl/ar_pkg.sv
package ar_pkg;

  localparam int AR_WORD_W = 32;
  localparam int AR_BYTE_W = 8;
  localparam int AR_LANES  = AR_WORD_W / AR_BYTE_W;
  localparam int AR_LSB    = $clog2(AR_LANES);

  typedef logic [AR_WORD_W-1:0] ar_word_t;
  typedef logic [AR_BYTE_W-1:0] ar_byte_t;
  typedef logic [AR_LSB-1:0]    ar_lane_t;

  // Byte of a word at a given lane, lane 0 being the least significant.
  function automatic ar_byte_t ar_lane_of(ar_word_t w, ar_lane_t lane);
    return w[int'(lane)*AR_BYTE_W +: AR_BYTE_W];
  endfunction

  // Word part of a byte address.
  function automatic int unsigned ar_word_idx(int unsigned byte_addr);
    return byte_addr >> AR_LSB;
  endfunction

endpackage

// File: rtl/ar_rd_addr_reg.sv
module ar_rd_addr_reg #(
  parameter int RAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] rd_addr,
  output logic [RAW-1:0] rd_addr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_addr_q <= '0;
    else        rd_addr_q <= rd_addr;
  end

endmodule

// File: rtl/ar_byte_store.sv
module ar_byte_store
  import ar_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            wr_fire,
  input  logic [AW-1:0]   wr_addr,
  input  ar_word_t        wr_data,
  input  logic [AW+AR_LSB-1:0] rd_addr_q,
  output ar_byte_t        rd_data
);

  localparam int NBYTES = (1 << AW) * AR_LANES;

  ar_byte_t mem [NBYTES];

  // One edge fills every lane of the addressed word.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      for (int l = 0; l < AR_LANES; l++) begin
        mem[{wr_addr, AR_LSB'(l)}] <= ar_lane_of(wr_data, AR_LSB'(l));
      end
    end
  end

  // Single narrow lookup: the lane bits are part of the array index.
  assign rd_data = mem[rd_addr_q];

endmodule

// File: rtl/asym_ram.sv
module asym_ram
  import ar_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [AW+1:0]        rd_addr,
  output logic [7:0]           rd_data
);

  localparam int RAW = AW + AR_LSB;

  logic           wr_fire;
  logic [RAW-1:0] rd_addr_q;

  assign wr_fire = wr_en && rst_n;

  ar_rd_addr_reg #(.RAW(RAW)) u_rd_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .rd_addr_q (rd_addr_q)
  );

  ar_byte_store #(.AW(AW)) u_store (
    .clk       (clk),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_q (rd_addr_q),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/ar_checker.sv
module ar_checker
  import ar_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic [AW+1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic [AW+1:0] rd_addr_q
);

  AST_RESET_ADDR: assert property (@(posedge clk)
    !rst_n |=> rd_addr_q == '0);  // R6

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> rd_addr_q == $past(rd_addr));  // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_addr == rd_addr_q) |=> $stable(rd_data));  // R2

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr[AW+1:2])
      |=> rd_data == ar_lane_of($past(wr_data), $past(rd_addr[1:0])));  // R5

endmodule

bind asym_ram ar_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .rd_addr_q (rd_addr_q)
);

// File: tb/tb_asym_ram.sv
`timescale 1ns/1ps
module tb_asym_ram;

  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW+1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [WORDS];

  always #2 clk = ~clk;

  asym_ram #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_byte(int unsigned ba);
    logic [31:0] w;
    w = model[ba / 4];
    return 8'((w >> (8 * (ba % 4))) & 32'hFF);
  endfunction

  function automatic logic [31:0] pat(int unsigned w, int unsigned salt);
    return (w * 32'h01030507) ^ (salt * 32'h9E3779B9) ^ {8'(w), 8'(w + 1), 8'(w + 2), 8'(w + 3)};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, let the rising edge capture them,
  // update the model, then compare just after the edge.
  task automatic cyc(logic we, int unsigned wa, logic [31:0] wd, int unsigned ra, string req);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd; rd_addr = (AW+2)'(ra);
    @(posedge clk);
    if (we && rst_n) model[wa] = wd;
    #1;
    check(req, rd_data, exp_byte(ra));
  endtask

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R7: fill every word, then read every byte of every word (R3 lanes).
    for (int w = 0; w < WORDS; w++) cyc(1'b1, w, pat(w, 1), 0, "R1");
    for (int b = 0; b < WORDS * 4; b++) cyc(1'b0, 0, 32'h0, b, "R7_R3");

    // R3: explicit lane order on a known word.
    cyc(1'b1, 5, 32'h44332211, 0, "R1");
    for (int l = 0; l < 4; l++) begin
      cyc(1'b0, 0, 32'h0, 5 * 4 + l, "R3");
      check("R3", rd_data, 8'(8'h11 * (l + 1)));
    end

    // R2: disabled writes with busy address/data leave contents alone.
    for (int w = 0; w < WORDS; w++) cyc(1'b0, w, 32'hDEADBEEF, w * 4 + (w % 4), "R2");
    for (int b = 0; b < WORDS * 4; b++) cyc(1'b0, b % WORDS, ~pat(b, 7), b, "R2");

    // R5: same-word collisions on every lane.
    for (int w = 0; w < WORDS; w++)
      for (int l = 0; l < 4; l++) cyc(1'b1, w, pat(w, 10 + l), w * 4 + l, "R5");

    // R4: address change between edges does not affect the output.
    cyc(1'b0, 0, 32'h0, 5 * 4 + 2, "R4");
    @(negedge clk); rd_addr = (AW+2)'(9 * 4 + 1); wr_en = 1'b0; #1;
    check("R4", rd_data, exp_byte(5 * 4 + 2));
    @(posedge clk); #1;
    check("R4", rd_data, exp_byte(9 * 4 + 1));

    // Random traffic with collisions against the byte model.
    for (int n = 0; n < 600; n++) begin
      int unsigned wa, ra;
      wa = $urandom_range(WORDS - 1);
      ra = ($urandom_range(3) == 0) ? wa * 4 + $urandom_range(3) : $urandom_range(WORDS * 4 - 1);
      cyc(1'($urandom_range(1)), wa, $urandom, ra, "R5_R7");
    end
    for (int b = 0; b < WORDS * 4; b++) cyc(1'b0, 0, 32'h0, b, "R7");

    // R6: reset clears the captured address and blocks writes.
    cyc(1'b1, 0, 32'hA1B2C3D4, 3, "R1");
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b1; wr_addr = '0; wr_data = 32'hFFFFFFFF; rd_addr = (AW+2)'(7);
    @(posedge clk); #1;
    check("R6", rd_data, 8'hD4);
    @(negedge clk); rst_n = 1'b1; wr_en = 1'b0;
    cyc(1'b0, 0, 32'h0, 3, "R6");
    check("R6", rd_data, 8'hA1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule